// File: doc/BRIEF.md
# Exception Vector Remap and Bus Abort Decoder

This block sits on the address path of a 32-bit processor bus, between the core and the memory and peripheral fabric. Each request carries an address and a flag that marks it as an instruction fetch or a data access. In the same cycle the block returns four things: a one-hot code naming the target region, the physical address that the region should serve, and two separate abort flags, one for data accesses and one for fetches. The abort flags are raised when a request lands in unimplemented space, and when a fetch is aimed at a peripheral.

The lowest 64 bytes of the address space form the exception-vector window. A 2-bit mapping register, written through a one-cycle write strobe, selects the source of that window: the boot block, the flash, or the SRAM. The source memory also remains reachable at its own native address. The flash size, SRAM size and base, boot block range, and the set of populated peripheral slots in the two 2 MB peripheral banks are all parameters.

Top module: `vec_remap_decoder`

## Requirements
- R1: After reset the mapping is boot-block mode. Any address A with A < 0x40 translates to BOOT_BASE + A and selects the boot region. BOOT_BASE defaults to 0x7FFF_D000.
- R2: With mapping code 2'b01 (flash mode), window addresses are passed through unchanged and select the flash region.
- R3: With mapping code 2'b10 (SRAM mode), a window address A translates to SRAM_BASE + A and selects SRAM. For example, 0x0000_0008 becomes 0x4000_0008.
- R4: Writing mapping code 2'b11 behaves exactly like code 2'b00. The window is served from the boot block.
- R5: Only 0x00 to 0x3F is redirected. 0x3F is redirected, while 0x40 and every address above the window translate to themselves.
- R6: Addresses inside SRAM and inside the boot block select those regions at their native addresses in every mapping mode.
- R7: Addresses below FLASH_BYTES select flash. Addresses from FLASH_BYTES up to 0x3FFF_FFFF are reserved.
- R8: SRAM covers SRAM_BASE to SRAM_BASE + SRAM_BYTES - 1. The range from there up to BOOT_BASE - 1 (0x7FFF_CFFF by default) is reserved. The boot block covers BOOT_BASE to 0x7FFF_FFFF.
- R9: 0x8000_0000 to 0xDFFF_FFFF is reserved. So is the gap 0xE020_0000 to 0xFFDF_FFFF between the two peripheral banks.
- R10: The peripheral banks start at 0xE000_0000 and 0xFFE0_0000. Each bank holds 128 slots of 16 kB, and the slot index is address bits [20:14]. A data access at any offset inside a populated slot selects the peripheral region and does not abort.
- R11: A slot whose bit is clear in its bank's population mask is treated as reserved.
- R12: A data access to reserved space raises the data abort only. A fetch from reserved or peripheral space raises the fetch abort only.
- R13: Exactly one region bit is set for every request. regionSel bit 0 is flash, bit 1 is SRAM, bit 2 is the boot block, bit 3 is a peripheral and bit 4 is reserved.
- R14: Outputs follow the request in the same cycle. A mapping write takes effect from the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mapWr | input | 1 | Write strobe for the mapping register |
| mapData | input | 2 | New mapping code (00 boot, 01 flash, 10 SRAM, 11 treated as boot) |
| reqAddr | input | 32 | Request address from the core |
| reqFetch | input | 1 | 1 for an instruction fetch, 0 for a data access |
| regionSel | output | 5 | One-hot target region |
| localAddr | output | 32 | Translated physical address |
| dataAbort | output | 1 | Data access to reserved space |
| prefAbort | output | 1 | Fetch from reserved or peripheral space |

## Verification
The bench builds the block with its defaults: 32 kB of flash, 8 kB of SRAM at 0x4000_0000, and a boot block from 0x7FFF_D000 to the top of the low 2 GB. In the lower peripheral bank, slots 0 to 11 and slot 127 are populated; in the upper bank only slot 127 is. With these sizes the edges of the flash, the SRAM and the boot block sit at short, distinct addresses, so each one is probed on both sides. The sparse masks put a populated slot right next to an empty one in both banks.

// File: rtl/vrd_pkg.sv
package vrd_pkg;

  localparam int SEL_FLASH  = 0;
  localparam int SEL_SRAM   = 1;
  localparam int SEL_BOOT   = 2;
  localparam int SEL_PERIPH = 3;
  localparam int SEL_RSVD   = 4;
  localparam int SEL_W      = 5;

  typedef enum logic [1:0] {
    MAP_BOOT  = 2'b00,
    MAP_FLASH = 2'b01,
    MAP_SRAM  = 2'b10
  } vecMap_e;

  // strobes from control to datapath
  typedef struct packed {
    logic winHit;
    logic toSram;
    logic toBoot;
  } remapStrobe_t;

endpackage

// File: rtl/vrd_ctrl.sv
module vrd_ctrl
  import vrd_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int WIN_BITS = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       mapWr,
  input  logic [1:0]                 mapData,
  input  logic [ADDR_W-WIN_BITS-1:0] winTag,
  output remapStrobe_t               strobe
);

  vecMap_e mapReg;
  vecMap_e mapNext;

  // the reserved code folds onto boot mode so no undefined source exists
  always_comb begin
    case (mapData)
      2'b01:   mapNext = MAP_FLASH;
      2'b10:   mapNext = MAP_SRAM;
      default: mapNext = MAP_BOOT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mapReg <= MAP_BOOT;
    else if (mapWr) mapReg <= mapNext;
  end

  always_comb begin
    strobe.winHit = (winTag == '0);
    strobe.toSram = strobe.winHit && (mapReg == MAP_SRAM);
    strobe.toBoot = strobe.winHit && (mapReg == MAP_BOOT);
  end

endmodule

// File: rtl/vrd_xlate.sv
module vrd_xlate
  import vrd_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          WIN_BITS  = 6,
  parameter logic [31:0] SRAM_BASE = 32'h4000_0000,
  parameter logic [31:0] BOOT_BASE = 32'h7FFF_D000
) (
  input  logic [ADDR_W-1:0] reqAddr,
  input  remapStrobe_t      strobe,
  output logic [ADDR_W-1:0] physAddr
);

  localparam int PAD_W = ADDR_W - WIN_BITS;

  logic [ADDR_W-1:0] winOfs;
  assign winOfs = {{PAD_W{1'b0}}, reqAddr[WIN_BITS-1:0]};

  always_comb begin
    if (strobe.toSram)      physAddr = SRAM_BASE[ADDR_W-1:0] + winOfs;
    else if (strobe.toBoot) physAddr = BOOT_BASE[ADDR_W-1:0] + winOfs;
    else                    physAddr = reqAddr;
  end

endmodule

// File: rtl/vrd_classify.sv
module vrd_classify
  import vrd_pkg::*;
#(
  parameter int          ADDR_W      = 32,
  parameter logic [31:0] FLASH_BYTES = 32'h0000_8000,
  parameter logic [31:0] SRAM_BASE   = 32'h4000_0000,
  parameter logic [31:0] SRAM_BYTES  = 32'h0000_2000,
  parameter logic [31:0] BOOT_BASE   = 32'h7FFF_D000,
  parameter logic [31:0] BOOT_LAST   = 32'h7FFF_FFFF,
  parameter int          BANK_BITS   = 11,
  parameter int          SLOT_BITS   = 7,
  parameter logic [BANK_BITS-1:0] LO_TAG = 11'h700,
  parameter logic [BANK_BITS-1:0] HI_TAG = 11'h7FF,
  parameter logic [(1<<SLOT_BITS)-1:0] LO_MASK = '1,
  parameter logic [(1<<SLOT_BITS)-1:0] HI_MASK = '1
) (
  input  logic [ADDR_W-1:0] physAddr,
  input  logic              reqFetch,
  output logic [SEL_W-1:0]  regionSel,
  output logic              dataAbort,
  output logic              prefAbort
);

  localparam int NSLOT    = 1 << SLOT_BITS;
  localparam int NBANK    = 2;
  localparam int SLOT_LSB = ADDR_W - BANK_BITS - SLOT_BITS;
  localparam logic [NBANK-1:0][BANK_BITS-1:0] BANK_TAG  = {HI_TAG, LO_TAG};
  localparam logic [NBANK-1:0][NSLOT-1:0]     BANK_MASK = {HI_MASK, LO_MASK};

  logic [BANK_BITS-1:0] addrTag;
  logic [SLOT_BITS-1:0] slotIdx;
  logic [NBANK-1:0]     bankHit;
  logic [NBANK-1:0]     slotLive;
  logic                 isFlash, isSram, isBoot, isPeriph;
  logic [ADDR_W-1:0]    sramOfs;

  assign addrTag = physAddr[ADDR_W-1 -: BANK_BITS];
  assign slotIdx = physAddr[SLOT_LSB +: SLOT_BITS];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign bankHit[b]  = (addrTag == BANK_TAG[b]);
    assign slotLive[b] = BANK_MASK[b][slotIdx];
  end

  assign sramOfs  = physAddr - SRAM_BASE[ADDR_W-1:0];
  assign isFlash  = physAddr < FLASH_BYTES[ADDR_W-1:0];
  assign isSram   = (physAddr >= SRAM_BASE[ADDR_W-1:0]) && (sramOfs < SRAM_BYTES[ADDR_W-1:0]);
  assign isBoot   = (physAddr >= BOOT_BASE[ADDR_W-1:0]) && (physAddr <= BOOT_LAST[ADDR_W-1:0]);
  assign isPeriph = |(bankHit & slotLive);

  always_comb begin
    regionSel = '0;
    if (isFlash)       regionSel[SEL_FLASH]  = 1'b1;
    else if (isSram)   regionSel[SEL_SRAM]   = 1'b1;
    else if (isBoot)   regionSel[SEL_BOOT]   = 1'b1;
    else if (isPeriph) regionSel[SEL_PERIPH] = 1'b1;
    else               regionSel[SEL_RSVD]   = 1'b1;
  end

  assign dataAbort = regionSel[SEL_RSVD] && !reqFetch;
  assign prefAbort = reqFetch && (regionSel[SEL_RSVD] || regionSel[SEL_PERIPH]);

endmodule

// File: rtl/vec_remap_decoder.sv
module vec_remap_decoder
  import vrd_pkg::*;
#(
  parameter int          ADDR_W      = 32,
  parameter int          WIN_BITS    = 6,
  parameter logic [31:0] FLASH_BYTES = 32'h0000_8000,
  parameter logic [31:0] SRAM_BASE   = 32'h4000_0000,
  parameter logic [31:0] SRAM_BYTES  = 32'h0000_2000,
  parameter logic [31:0] BOOT_BASE   = 32'h7FFF_D000,
  parameter logic [31:0] BOOT_LAST   = 32'h7FFF_FFFF,
  parameter int          BANK_BITS   = 11,
  parameter int          SLOT_BITS   = 7,
  parameter logic [BANK_BITS-1:0] LO_TAG = 11'h700,
  parameter logic [BANK_BITS-1:0] HI_TAG = 11'h7FF,
  parameter logic [(1<<SLOT_BITS)-1:0] LO_MASK = {1'b1, {((1<<SLOT_BITS)-13){1'b0}}, 12'hFFF},
  parameter logic [(1<<SLOT_BITS)-1:0] HI_MASK = {1'b1, {((1<<SLOT_BITS)-1){1'b0}}}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mapWr,
  input  logic [1:0]        mapData,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqFetch,
  output logic [SEL_W-1:0]  regionSel,
  output logic [ADDR_W-1:0] localAddr,
  output logic              dataAbort,
  output logic              prefAbort
);

  remapStrobe_t strobe;

  vrd_ctrl #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .mapWr   (mapWr),
    .mapData (mapData),
    .winTag  (reqAddr[ADDR_W-1:WIN_BITS]),
    .strobe  (strobe)
  );

  vrd_xlate #(
    .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS),
    .SRAM_BASE(SRAM_BASE), .BOOT_BASE(BOOT_BASE)
  ) u_xlate (
    .reqAddr  (reqAddr),
    .strobe   (strobe),
    .physAddr (localAddr)
  );

  vrd_classify #(
    .ADDR_W(ADDR_W), .FLASH_BYTES(FLASH_BYTES), .SRAM_BASE(SRAM_BASE),
    .SRAM_BYTES(SRAM_BYTES), .BOOT_BASE(BOOT_BASE), .BOOT_LAST(BOOT_LAST),
    .BANK_BITS(BANK_BITS), .SLOT_BITS(SLOT_BITS),
    .LO_TAG(LO_TAG), .HI_TAG(HI_TAG), .LO_MASK(LO_MASK), .HI_MASK(HI_MASK)
  ) u_classify (
    .physAddr  (localAddr),
    .reqFetch  (reqFetch),
    .regionSel (regionSel),
    .dataAbort (dataAbort),
    .prefAbort (prefAbort)
  );

endmodule

// File: rtl/vrd_checker.sv
module vrd_checker #(
  parameter int          ADDR_W    = 32,
  parameter int          WIN_BITS  = 6,
  parameter logic [31:0] SRAM_BASE = 32'h4000_0000,
  parameter logic [31:0] BOOT_BASE = 32'h7FFF_D000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mapWr,
  input logic [1:0]        mapData,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              reqFetch,
  input logic [4:0]        regionSel,
  input logic [ADDR_W-1:0] localAddr,
  input logic              dataAbort,
  input logic              prefAbort
);

  logic              inWin;
  logic [ADDR_W-1:0] winOfs;
  assign inWin  = (reqAddr[ADDR_W-1:WIN_BITS] == '0);
  assign winOfs = {{(ADDR_W-WIN_BITS){1'b0}}, reqAddr[WIN_BITS-1:0]};

  // R13: exactly one region
  a_r13_one_region: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(regionSel) == 1);

  // R12: never both abort kinds
  a_r12_abort_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(dataAbort && prefAbort));

  // R12: fetch into peripheral space aborts as a fetch abort
  a_r12_fetch_periph: assert property (@(posedge clk) disable iff (!rst_n)
    (regionSel[3] && reqFetch) |-> prefAbort);

  // R10: data access to a populated slot is clean
  a_r10_data_periph: assert property (@(posedge clk) disable iff (!rst_n)
    (regionSel[3] && !reqFetch) |-> (!dataAbort && !prefAbort));

  // R11: data access to reserved space aborts
  a_r11_rsvd_data: assert property (@(posedge clk) disable iff (!rst_n)
    (regionSel[4] && !reqFetch) |-> dataAbort);

  // R5: outside the window the address passes unchanged
  a_r5_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    !inWin |-> (localAddr == reqAddr));

  // R3: an SRAM-mode write redirects the window from the next cycle
  a_r3_sram_map: assert property (@(posedge clk) disable iff (!rst_n)
    (mapWr && mapData == 2'b10) |=> (!inWin || localAddr == SRAM_BASE[ADDR_W-1:0] + winOfs));

  // R4: the reserved code acts as boot mode
  a_r4_code11_boot: assert property (@(posedge clk) disable iff (!rst_n)
    (mapWr && mapData == 2'b11) |=> (!inWin || localAddr == BOOT_BASE[ADDR_W-1:0] + winOfs));

endmodule

bind vec_remap_decoder vrd_checker #(
  .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .SRAM_BASE(SRAM_BASE), .BOOT_BASE(BOOT_BASE)
) u_vrd_checker (
  .clk(clk), .rst_n(rst_n), .mapWr(mapWr), .mapData(mapData),
  .reqAddr(reqAddr), .reqFetch(reqFetch), .regionSel(regionSel),
  .localAddr(localAddr), .dataAbort(dataAbort), .prefAbort(prefAbort)
);

// File: tb/vec_remap_decoder_bench.sv
module vec_remap_decoder_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mapWr = 1'b0;
  logic [1:0]  mapData = 2'b00;
  logic [31:0] reqAddr = 32'h0;
  logic        reqFetch = 1'b0;
  logic [4:0]  regionSel;
  logic [31:0] localAddr;
  logic        dataAbort, prefAbort;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  vec_remap_decoder u_vec_remap_decoder (
    .clk(clk), .rst_n(rst_n), .mapWr(mapWr), .mapData(mapData),
    .reqAddr(reqAddr), .reqFetch(reqFetch), .regionSel(regionSel),
    .localAddr(localAddr), .dataAbort(dataAbort), .prefAbort(prefAbort)
  );

  localparam logic [4:0] S_FL = 5'b00001;
  localparam logic [4:0] S_SR = 5'b00010;
  localparam logic [4:0] S_BT = 5'b00100;
  localparam logic [4:0] S_PE = 5'b01000;
  localparam logic [4:0] S_RS = 5'b10000;

  typedef struct packed {
    logic [1:0]  mode;
    logic [31:0] addr;
    logic        fetch;
    logic [4:0]  sel;
    logic [31:0] loc;
    logic        dab;
    logic        pab;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 32'h0000_0008, 1'b1, S_BT, 32'h7FFF_D008, 1'b0, 1'b0, 8'd1 },  // R1
    '{2'd0, 32'h0000_003C, 1'b0, S_BT, 32'h7FFF_D03C, 1'b0, 1'b0, 8'd5 },  // R5
    '{2'd1, 32'h0000_0008, 1'b1, S_FL, 32'h0000_0008, 1'b0, 1'b0, 8'd2 },  // R2
    '{2'd2, 32'h0000_0008, 1'b0, S_SR, 32'h4000_0008, 1'b0, 1'b0, 8'd3 },  // R3
    '{2'd2, 32'h0000_003F, 1'b0, S_SR, 32'h4000_003F, 1'b0, 1'b0, 8'd5 },  // R5
    '{2'd2, 32'h0000_0040, 1'b0, S_FL, 32'h0000_0040, 1'b0, 1'b0, 8'd5 },  // R5
    '{2'd2, 32'h7FFF_D008, 1'b1, S_BT, 32'h7FFF_D008, 1'b0, 1'b0, 8'd6 },  // R6
    '{2'd2, 32'h4000_0010, 1'b0, S_SR, 32'h4000_0010, 1'b0, 1'b0, 8'd6 },  // R6
    '{2'd1, 32'h0000_7FFF, 1'b0, S_FL, 32'h0000_7FFF, 1'b0, 1'b0, 8'd7 },  // R7
    '{2'd1, 32'h0000_8000, 1'b0, S_RS, 32'h0000_8000, 1'b1, 1'b0, 8'd7 },  // R7
    '{2'd1, 32'h0000_8000, 1'b1, S_RS, 32'h0000_8000, 1'b0, 1'b1, 8'd12},  // R12
    '{2'd1, 32'h4000_1FFF, 1'b0, S_SR, 32'h4000_1FFF, 1'b0, 1'b0, 8'd8 },  // R8
    '{2'd1, 32'h4000_2000, 1'b0, S_RS, 32'h4000_2000, 1'b1, 1'b0, 8'd8 },  // R8
    '{2'd1, 32'h7FFF_CFFC, 1'b0, S_RS, 32'h7FFF_CFFC, 1'b1, 1'b0, 8'd8 },  // R8
    '{2'd1, 32'h7FFF_FFFC, 1'b1, S_BT, 32'h7FFF_FFFC, 1'b0, 1'b0, 8'd8 },  // R8
    '{2'd1, 32'h8000_0000, 1'b0, S_RS, 32'h8000_0000, 1'b1, 1'b0, 8'd9 },  // R9
    '{2'd1, 32'hDFFF_FFFC, 1'b0, S_RS, 32'hDFFF_FFFC, 1'b1, 1'b0, 8'd9 },  // R9
    '{2'd1, 32'hE020_0000, 1'b0, S_RS, 32'hE020_0000, 1'b1, 1'b0, 8'd9 },  // R9
    '{2'd1, 32'hE01F_C040, 1'b0, S_PE, 32'hE01F_C040, 1'b0, 1'b0, 8'd10},  // R10
    '{2'd1, 32'hE000_3FFC, 1'b0, S_PE, 32'hE000_3FFC, 1'b0, 1'b0, 8'd10},  // R10
    '{2'd1, 32'hE003_0000, 1'b0, S_RS, 32'hE003_0000, 1'b1, 1'b0, 8'd11},  // R11
    '{2'd1, 32'hFFFF_F010, 1'b0, S_PE, 32'hFFFF_F010, 1'b0, 1'b0, 8'd10},  // R10
    '{2'd1, 32'hFFE0_0000, 1'b0, S_RS, 32'hFFE0_0000, 1'b1, 1'b0, 8'd11},  // R11
    '{2'd1, 32'hE000_0000, 1'b1, S_PE, 32'hE000_0000, 1'b0, 1'b1, 8'd12},  // R12
    '{2'd3, 32'h0000_0008, 1'b0, S_BT, 32'h7FFF_D008, 1'b0, 1'b0, 8'd4 },  // R4
    '{2'd3, 32'h0000_0020, 1'b1, S_BT, 32'h7FFF_D020, 1'b0, 1'b0, 8'd4 }   // R4
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic setMode(input logic [1:0] m);
    @(negedge clk);
    mapWr = 1'b1;
    mapData = m;
    @(negedge clk);
    mapWr = 1'b0;
  endtask

  task automatic probe(input logic [31:0] a, input logic f);
    reqAddr = a;
    reqFetch = f;
    #2;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state, vector window served from the boot block
    probe(32'h0000_0004, 1'b0);
    check("R1 reset sel", {27'b0, regionSel}, {27'b0, S_BT});
    check("R1 reset addr", localAddr, 32'h7FFF_D004);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      setMode(VEC[i].mode);
      probe(VEC[i].addr, VEC[i].fetch);
      check($sformatf("R%0d sel vec%0d", VEC[i].req, i), {27'b0, regionSel}, {27'b0, VEC[i].sel});
      check($sformatf("R%0d addr vec%0d", VEC[i].req, i), localAddr, VEC[i].loc);
      check($sformatf("R%0d dabort vec%0d", VEC[i].req, i), {31'b0, dataAbort}, {31'b0, VEC[i].dab});
      check($sformatf("R%0d pabort vec%0d", VEC[i].req, i), {31'b0, prefAbort}, {31'b0, VEC[i].pab});
      // R13: one region bit
      check("R13 onehot", $countones(regionSel), 32'd1);
    end

    // R14: write takes effect only after the edge
    setMode(2'b00);
    @(negedge clk);
    mapWr = 1'b1;
    mapData = 2'b10;
    probe(32'h0000_0010, 1'b0);
    check("R14 before edge", localAddr, 32'h7FFF_D010);
    @(negedge clk);
    mapWr = 1'b0;
    #2;
    check("R14 after edge", localAddr, 32'h4000_0010);

    // R1: reset returns mapping from SRAM mode to boot mode
    rst_n = 1'b0;
    #2;
    check("R1 reset again", localAddr, 32'h7FFF_D010);
    @(negedge clk);
    rst_n = 1'b1;
    probe(32'h0000_0010, 1'b0);
    check("R1 after reset release", {27'b0, regionSel}, {27'b0, S_BT});

    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

endmodule